// File: doc/BRIEF.md
# Cycle-by-cycle multi-context scheduler

This block chooses, on every clock cycle, which of several hardware instruction contexts sends its program counter into a pipeline that all contexts share. Each context keeps a 2-bit state and its own program counter. A context becomes runnable when a start command places a new process in a free slot. It is parked while it waits for a reply and becomes runnable again when the reply returns. A stop command halts it. Contexts that cannot run are skipped, and the runnable ones take turns in a fixed circular order.

The block also remembers which context issued each of the last three instructions. These are the instructions behind a branch or load that resolves in the execute stage. When such an instruction resolves with a new target, the block raises an invalidate flag only for the younger slots that hold the same context, and it reloads that context's program counter. With four runnable contexts taking turns, those three slots always hold other contexts, so nothing is ever discarded. When no context can run, the block inserts a bubble and flags the pipeline as idle.

Top module: `ctx_sched`

## Requirements
- R1: While reset is held and on the first cycle after it is released, every context state is free, issue_valid is 0, pipe_sleep is 1 and slot_kill is 0.
- R2: ctx_status holds context i in bits [2i+1:2i], with the encoding 00 free, 01 runnable, 10 waiting for a reply, 11 halted.
- R3: A start command moves the lowest-numbered context whose state is 00 or 11 to state 01 on the next cycle and loads its counter with start_pc. If no context is 00 or 11, the command changes nothing.
- R4: The issued context is the first eligible context after the one issued last, in ascending order and wrapping from the highest to 0. The reference point after reset is the highest context, so context 0 is tried first. A context is eligible when its state is 01 and it is not the target of a resolve in the same cycle.
- R5: issue_pc is the issued context's counter. After each issue, that counter increments by 1, modulo 2^PC_W.
- R6: A sleep on a runnable context sets its state to 10 on the next cycle. A wake on a waiting context sets its state to 01. A sleep or wake that targets any other state has no effect.
- R7: A stop on a context in state 01 or 10 sets it to 11 on the next cycle. A stop takes priority over a sleep or wake on the same context in the same cycle.
- R8: When no context is eligible, issue_valid is 0 and pipe_sleep is 1. Otherwise issue_valid is 1 and pipe_sleep is 0.
- R9: A resolve loads resolve_pc into the target context's counter on the next cycle. The target context is not issued in the resolve cycle. A start to the same context in the same cycle wins.
- R10: During a resolve, slot_kill[k] is 1 exactly when the instruction issued k+1 cycles earlier was valid, belonged to resolve_ctx and had not already been invalidated.
- R11: With all four contexts runnable in turn, a resolve for the context issued four cycles earlier gives slot_kill equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Start a new process in a free context |
| start_pc | input | PC_W | Entry address of the new process |
| sleep_valid | input | 1 | Park a context waiting for a reply |
| sleep_ctx | input | CTX_W | Context to park |
| wake_valid | input | 1 | Reply received for a context |
| wake_ctx | input | CTX_W | Context to wake |
| stop_valid | input | 1 | Halt a context |
| stop_ctx | input | CTX_W | Context to halt |
| resolve_valid | input | 1 | Taken branch or load replay resolving in execute |
| resolve_ctx | input | CTX_W | Context of the resolving instruction |
| resolve_pc | input | PC_W | New counter value for that context |
| issue_valid | output | 1 | A context is issued this cycle |
| issue_ctx | output | CTX_W | Issued context |
| issue_pc | output | PC_W | Counter of the issued context |
| pipe_sleep | output | 1 | No context can run (bubble) |
| slot_kill | output | DELAY | Invalidate flags, bit k for the instruction issued k+1 cycles ago |
| ctx_status | output | 2*NUM_CTX | Packed per-context state |

## Verification
A wrong state bit shows on ctx_status one cycle after the command that caused it. From the same cycle it also shows in the issue order, because a context is either skipped or issued out of turn. A stale round-robin pointer or counter shows on the next issue as a wrong issue_ctx or issue_pc. A corrupted in-flight record stays hidden until a resolve reaches that context, and then it appears at once as a wrong slot_kill pattern. A sweep with random commands, compared every cycle against an arithmetic model, brings each of these cases out within a few cycles of when it occurs.

// File: rtl/ctx_sched_pkg.sv
// Shared types of the multi-context scheduler.
// Assumes: a context state fits in two bits.
package ctx_sched_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'b00,
        ST_RUN  = 2'b01,
        ST_WAIT = 2'b10,
        ST_HALT = 2'b11
    } ctx_state_e;
endpackage

// File: rtl/ctx_status_bank.sv
// Per-context state and program counter storage.
// Does: applies start, stop, sleep and wake commands to the states, and
// loads, redirects or advances the counters.
// Assumes: commands are single-cycle pulses, and at most one command of each
// kind arrives per cycle.
module ctx_status_bank
    import ctx_sched_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int PC_W    = 16,
    parameter int CTX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    input  logic [PC_W-1:0]  start_pc,
    input  logic             sleep_valid,
    input  logic [CTX_W-1:0] sleep_ctx,
    input  logic             wake_valid,
    input  logic [CTX_W-1:0] wake_ctx,
    input  logic             stop_valid,
    input  logic [CTX_W-1:0] stop_ctx,
    input  logic             resolve_valid,
    input  logic [CTX_W-1:0] resolve_ctx,
    input  logic [PC_W-1:0]  resolve_pc,
    input  logic             adv_valid,
    input  logic [CTX_W-1:0] adv_ctx,
    output ctx_state_e       st_o [NUM_CTX],
    output logic [PC_W-1:0]  pc_o [NUM_CTX],
    output logic [NUM_CTX-1:0] run_mask
);
    ctx_state_e          st_q [NUM_CTX];
    logic [PC_W-1:0]     pc_q [NUM_CTX];
    logic [NUM_CTX-1:0]  start_hit;
    logic                slot_taken;

    // Choose the lowest-numbered context that is free or halted for a start.
    always_comb begin
        start_hit  = '0;
        slot_taken = 1'b0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (start_valid && !slot_taken &&
                (st_q[i] == ST_FREE || st_q[i] == ST_HALT)) begin
                start_hit[i] = 1'b1;
                slot_taken   = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        // State update for one context; a start, then a stop, then a sleep, then a wake.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i] <= ST_FREE;
            end else if (start_hit[i]) begin
                st_q[i] <= ST_RUN;
            end else if (stop_valid && stop_ctx == CTX_W'(i) &&
                         (st_q[i] == ST_RUN || st_q[i] == ST_WAIT)) begin
                st_q[i] <= ST_HALT;
            end else if (sleep_valid && sleep_ctx == CTX_W'(i) && st_q[i] == ST_RUN) begin
                st_q[i] <= ST_WAIT;
            end else if (wake_valid && wake_ctx == CTX_W'(i) && st_q[i] == ST_WAIT) begin
                st_q[i] <= ST_RUN;
            end
        end

        // Counter update for one context; a start, then a redirect, then an advance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[i] <= '0;
            end else if (start_hit[i]) begin
                pc_q[i] <= start_pc;
            end else if (resolve_valid && resolve_ctx == CTX_W'(i)) begin
                pc_q[i] <= resolve_pc;
            end else if (adv_valid && adv_ctx == CTX_W'(i)) begin
                pc_q[i] <= pc_q[i] + PC_W'(1);
            end
        end

        assign st_o[i]     = st_q[i];
        assign pc_o[i]     = pc_q[i];
        assign run_mask[i] = (st_q[i] == ST_RUN);
    end
endmodule

// File: rtl/ctx_rr_pick.sv
// Round-robin picker over the eligible contexts.
// Does: grants the first eligible context after the one granted last,
// wrapping around. The pointer moves only on a grant.
// Assumes: the eligibility mask is settled within the cycle.
module ctx_rr_pick #(
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] elig,
    output logic               grant_valid,
    output logic [CTX_W-1:0]   grant_ctx
);
    logic [CTX_W-1:0] last_q;
    logic [31:0]      cand;

    // Scan from the farthest offset down to the nearest, so the nearest eligible context wins.
    always_comb begin
        grant_valid = 1'b0;
        grant_ctx   = last_q;
        cand        = '0;
        for (int k = NUM_CTX; k >= 1; k--) begin
            cand = (32'(last_q) + 32'(k)) % 32'(NUM_CTX);
            if (elig[cand[CTX_W-1:0]]) begin
                grant_valid = 1'b1;
                grant_ctx   = cand[CTX_W-1:0];
            end
        end
    end

    // Remember the last granted context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= CTX_W'(NUM_CTX - 1);
        end else if (grant_valid) begin
            last_q <= grant_ctx;
        end
    end
endmodule

// File: rtl/ctx_slot_track.sv
// In-flight tracker for the delay window.
// Does: records the validity and context of the last DELAY issues, and flags
// the ones that share the resolving instruction's context.
// Assumes: the resolving instruction is the one issued DELAY+1 cycles earlier.
module ctx_slot_track #(
    parameter int CTX_W = 2,
    parameter int DELAY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [CTX_W-1:0] issue_ctx,
    input  logic             resolve_valid,
    input  logic [CTX_W-1:0] resolve_ctx,
    output logic [DELAY-1:0] kill
);
    logic             hv_q [DELAY];
    logic [CTX_W-1:0] hc_q [DELAY];

    // Flag the younger slots that belong to the resolving context.
    always_comb begin
        for (int s = 0; s < DELAY; s++) begin
            kill[s] = resolve_valid && hv_q[s] && (hc_q[s] == resolve_ctx);
        end
    end

    for (genvar s = 0; s < DELAY; s++) begin : g_slot
        if (s == 0) begin : g_head
            // Capture this cycle's issue.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hv_q[s] <= 1'b0;
                    hc_q[s] <= '0;
                end else begin
                    hv_q[s] <= issue_valid;
                    hc_q[s] <= issue_ctx;
                end
            end
        end else begin : g_tail
            // Age a slot and drop its valid bit once it has been invalidated.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hv_q[s] <= 1'b0;
                    hc_q[s] <= '0;
                end else begin
                    hv_q[s] <= hv_q[s-1] && !kill[s-1];
                    hc_q[s] <= hc_q[s-1];
                end
            end
        end
    end
endmodule

// File: rtl/ctx_sched.sv
// Top of the cycle-by-cycle multi-context scheduler.
// Does: issues one runnable context per cycle in round-robin order, or a
// bubble. Applies the context commands and invalidates same-context slots
// on a resolve.
// Assumes: all commands are synchronous to clk, and reset is synchronous and
// active low.
module ctx_sched
    import ctx_sched_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int PC_W    = 16,
    parameter int DELAY   = 3,
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_valid,
    input  logic [PC_W-1:0]        start_pc,
    input  logic                   sleep_valid,
    input  logic [CTX_W-1:0]       sleep_ctx,
    input  logic                   wake_valid,
    input  logic [CTX_W-1:0]       wake_ctx,
    input  logic                   stop_valid,
    input  logic [CTX_W-1:0]       stop_ctx,
    input  logic                   resolve_valid,
    input  logic [CTX_W-1:0]       resolve_ctx,
    input  logic [PC_W-1:0]        resolve_pc,
    output logic                   issue_valid,
    output logic [CTX_W-1:0]       issue_ctx,
    output logic [PC_W-1:0]        issue_pc,
    output logic                   pipe_sleep,
    output logic [DELAY-1:0]       slot_kill,
    output logic [2*NUM_CTX-1:0]   ctx_status
);
    ctx_state_e         st   [NUM_CTX];
    logic [PC_W-1:0]    pcs  [NUM_CTX];
    logic [NUM_CTX-1:0] run_mask;
    logic [NUM_CTX-1:0] hold_mask;
    logic [NUM_CTX-1:0] elig;

    ctx_status_bank #(.NUM_CTX(NUM_CTX), .PC_W(PC_W), .CTX_W(CTX_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_pc(start_pc),
        .sleep_valid(sleep_valid), .sleep_ctx(sleep_ctx),
        .wake_valid(wake_valid), .wake_ctx(wake_ctx),
        .stop_valid(stop_valid), .stop_ctx(stop_ctx),
        .resolve_valid(resolve_valid), .resolve_ctx(resolve_ctx), .resolve_pc(resolve_pc),
        .adv_valid(issue_valid), .adv_ctx(issue_ctx),
        .st_o(st), .pc_o(pcs), .run_mask(run_mask)
    );

    // A context being redirected this cycle sits out one turn.
    always_comb begin
        for (int i = 0; i < NUM_CTX; i++) begin
            hold_mask[i] = resolve_valid && (resolve_ctx == CTX_W'(i));
        end
    end
    assign elig = run_mask & ~hold_mask;

    ctx_rr_pick #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .elig(elig),
        .grant_valid(issue_valid), .grant_ctx(issue_ctx)
    );

    ctx_slot_track #(.CTX_W(CTX_W), .DELAY(DELAY)) u_track (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_ctx(issue_ctx),
        .resolve_valid(resolve_valid), .resolve_ctx(resolve_ctx),
        .kill(slot_kill)
    );

    assign issue_pc   = pcs[issue_ctx];
    assign pipe_sleep = !issue_valid;

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_pack
        assign ctx_status[2*i +: 2] = st[i];
    end
endmodule

// File: rtl/ctx_sched_chk.sv
// Property checker for ctx_sched, attached with bind.
// Does: checks the issue legality, the state transitions and the invalidate rules.
// Assumes: the same parameters as the bound instance.
module ctx_sched_chk #(
    parameter int NUM_CTX = 4,
    parameter int DELAY   = 3,
    parameter int CTX_W   = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sleep_valid,
    input logic [CTX_W-1:0]     sleep_ctx,
    input logic                 stop_valid,
    input logic [CTX_W-1:0]     stop_ctx,
    input logic                 resolve_valid,
    input logic [CTX_W-1:0]     resolve_ctx,
    input logic                 issue_valid,
    input logic [CTX_W-1:0]     issue_ctx,
    input logic [DELAY-1:0]     slot_kill,
    input logic [2*NUM_CTX-1:0] ctx_status
);
    logic [CTX_W-1:0] sleep_ctx_q;
    logic [CTX_W-1:0] stop_ctx_q;

    // Keep the previous command targets for the next-cycle checks.
    always_ff @(posedge clk) begin
        sleep_ctx_q <= sleep_ctx;
        stop_ctx_q  <= stop_ctx;
    end

    // R4
    issue_runnable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ctx_status[{issue_ctx, 1'b0} +: 2] == 2'b01);

    // R9
    resolve_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_valid |-> !(issue_valid && issue_ctx == resolve_ctx));

    // R10
    kill_needs_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_kill != '0) |-> resolve_valid);

    // R6
    sleep_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_valid && ctx_status[{sleep_ctx, 1'b0} +: 2] == 2'b01 &&
         !(stop_valid && stop_ctx == sleep_ctx))
        |=> ctx_status[{sleep_ctx_q, 1'b0} +: 2] == 2'b10);

    // R7
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_valid && (ctx_status[{stop_ctx, 1'b0} +: 2] == 2'b01 ||
                        ctx_status[{stop_ctx, 1'b0} +: 2] == 2'b10))
        |=> ctx_status[{stop_ctx_q, 1'b0} +: 2] == 2'b11);
endmodule

bind ctx_sched ctx_sched_chk #(.NUM_CTX(NUM_CTX), .DELAY(DELAY), .CTX_W(CTX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .sleep_valid(sleep_valid), .sleep_ctx(sleep_ctx),
    .stop_valid(stop_valid), .stop_ctx(stop_ctx),
    .resolve_valid(resolve_valid), .resolve_ctx(resolve_ctx),
    .issue_valid(issue_valid), .issue_ctx(issue_ctx),
    .slot_kill(slot_kill), .ctx_status(ctx_status)
);

// File: tb/ctx_sched_tb.sv
// Bench for ctx_sched: directed corner cases, then a random command sweep
// compared every cycle against an arithmetic model.
module ctx_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int PCW = 16;
    localparam int DLY = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_valid = 0, sleep_valid = 0, wake_valid = 0, stop_valid = 0, resolve_valid = 0;
    logic [PCW-1:0] start_pc = '0, resolve_pc = '0;
    logic [1:0] sleep_ctx = '0, wake_ctx = '0, stop_ctx = '0, resolve_ctx = '0;
    logic issue_valid, pipe_sleep;
    logic [1:0] issue_ctx;
    logic [PCW-1:0] issue_pc;
    logic [DLY-1:0] slot_kill;
    logic [2*N-1:0] ctx_status;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int mst [N];
    int mpc [N];
    int mlast;
    bit hv [DLY];
    int hc [DLY];
    // last sampled outputs
    bit l_iv;
    int l_kill;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_sched #(.NUM_CTX(N), .PC_W(PCW), .DELAY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_pc(start_pc),
        .sleep_valid(sleep_valid), .sleep_ctx(sleep_ctx),
        .wake_valid(wake_valid), .wake_ctx(wake_ctx),
        .stop_valid(stop_valid), .stop_ctx(stop_ctx),
        .resolve_valid(resolve_valid), .resolve_ctx(resolve_ctx), .resolve_pc(resolve_pc),
        .issue_valid(issue_valid), .issue_ctx(issue_ctx), .issue_pc(issue_pc),
        .pipe_sleep(pipe_sleep), .slot_kill(slot_kill), .ctx_status(ctx_status)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int model_pick(input bit rv, input int rc);
        int sel;
        sel = -1;
        for (int k = N; k >= 1; k--) begin
            int c;
            c = (mlast + k) % N;
            if (mst[c] == 1 && !(rv && rc == c)) sel = c;
        end
        return sel;
    endfunction

    function automatic int model_status();
        int v;
        v = 0;
        for (int i = 0; i < N; i++) v = v | (mst[i] << (2*i));
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin mst[i] = 0; mpc[i] = 0; end
        for (int s = 0; s < DLY; s++) begin hv[s] = 0; hc[s] = 0; end
        mlast = N - 1;
    endtask

    // One cycle: drive at the falling edge, compare, clock, then update the model.
    task automatic step(input bit sv, input int spc, input bit slv, input int slc,
                        input bit wv, input int wc, input bit tv, input int tc,
                        input bit rv, input int rc, input int rpc);
        int sel, ekill, tgt, ns [N];
        start_valid = sv; start_pc = PCW'(spc);
        sleep_valid = slv; sleep_ctx = 2'(slc);
        wake_valid = wv; wake_ctx = 2'(wc);
        stop_valid = tv; stop_ctx = 2'(tc);
        resolve_valid = rv; resolve_ctx = 2'(rc); resolve_pc = PCW'(rpc);
        #1;
        sel = model_pick(rv, rc);
        ekill = 0;
        for (int s = 0; s < DLY; s++) if (rv && hv[s] && hc[s] == rc) ekill = ekill | (1 << s);
        chk(issue_valid == (sel >= 0), "R8", "issue_valid", int'(issue_valid), int'(sel >= 0));
        chk(pipe_sleep == (sel < 0), "R8", "pipe_sleep", int'(pipe_sleep), int'(sel < 0));
        if (sel >= 0) begin
            chk(int'(issue_ctx) == sel, "R4", "issue_ctx", int'(issue_ctx), sel);
            chk(int'(issue_pc) == mpc[sel], "R5", "issue_pc", int'(issue_pc), mpc[sel]);
        end
        chk(int'(slot_kill) == ekill, "R10", "slot_kill", int'(slot_kill), ekill);
        chk(int'(ctx_status) == model_status(), "R2", "ctx_status", int'(ctx_status), model_status());
        l_iv = issue_valid; l_kill = int'(slot_kill);
        @(posedge clk);
        // model update
        tgt = -1;
        if (sv) for (int i = N-1; i >= 0; i--) if (mst[i] == 0 || mst[i] == 3) tgt = i;
        for (int i = 0; i < N; i++) begin
            ns[i] = mst[i];
            if (tgt == i) ns[i] = 1;
            else if (tv && tc == i && (mst[i] == 1 || mst[i] == 2)) ns[i] = 3;
            else if (slv && slc == i && mst[i] == 1) ns[i] = 2;
            else if (wv && wc == i && mst[i] == 2) ns[i] = 1;
            if (tgt == i) mpc[i] = spc;
            else if (rv && rc == i) mpc[i] = rpc;
            else if (sel == i) mpc[i] = (mpc[i] + 1) & 16'hffff;
        end
        for (int i = 0; i < N; i++) mst[i] = ns[i];
        for (int s = DLY-1; s >= 1; s--) begin
            hv[s] = hv[s-1] && !((ekill >> (s-1)) & 1);
            hc[s] = hc[s-1];
        end
        hv[0] = (sel >= 0); hc[0] = (sel >= 0) ? sel : 0;
        if (sel >= 0) mlast = sel;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0,0,0,0,0,0,0,0,0,0,0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        chk(ctx_status == '0, "R1", "status in reset", int'(ctx_status), 0);
        chk(issue_valid == 0 && pipe_sleep == 1, "R1", "bubble in reset", int'(issue_valid), 0);
        rst_n = 1'b1;
        #1;
        chk(slot_kill == '0, "R1", "slot_kill after reset", int'(slot_kill), 0);
        idle(2);

        // R3 start ctx0, R5 counter run
        step(1, 16'h0100, 0,0,0,0,0,0,0,0,0);
        chk(ctx_status[1:0] == 2'b01, "R3", "ctx0 started", int'(ctx_status[1:0]), 1);
        idle(4);
        // R9/R10: a lone context resolving invalidates all three slots and sits out
        step(0,0,0,0,0,0,0,0, 1, 0, 16'h0200);
        chk(l_kill == 7, "R10", "lone ctx kill", l_kill, 7);
        chk(l_iv == 0, "R9", "resolving ctx held", int'(l_iv), 0);
        step(0,0,0,0,0,0,0,0, 1, 0, 16'h0300);
        chk(l_kill == 0, "R10", "already killed slots", l_kill, 0);
        idle(2);

        // R3: fill the remaining contexts, then an extra start is ignored
        step(1, 16'h1000, 0,0,0,0,0,0,0,0,0);
        step(1, 16'h2000, 0,0,0,0,0,0,0,0,0);
        step(1, 16'h3000, 0,0,0,0,0,0,0,0,0);
        chk(ctx_status == 8'h55, "R3", "all runnable", int'(ctx_status), 8'h55);
        step(1, 16'h4000, 0,0,0,0,0,0,0,0,0);
        chk(ctx_status == 8'h55, "R3", "start with none free", int'(ctx_status), 8'h55);
        idle(5);

        // R11: four contexts in turn, a resolve of the next in line invalidates nothing
        for (int r = 0; r < 4; r++) begin
            int nx;
            nx = model_pick(0, 0);
            step(0,0,0,0,0,0,0,0, 1, nx, 16'h0500 + r);
            chk(l_kill == 0, "R11", "four-context resolve", l_kill, 0);
            idle(3);
        end

        // R6 sleep/wake, including ignored cases
        step(0,0, 1, 1, 0,0,0,0,0,0,0);
        chk(ctx_status[3:2] == 2'b10, "R6", "ctx1 parked", int'(ctx_status[3:2]), 2);
        idle(4);
        step(0,0, 1, 1, 0,0,0,0,0,0,0);
        chk(ctx_status[3:2] == 2'b10, "R6", "sleep on waiting ignored", int'(ctx_status[3:2]), 2);
        step(0,0,0,0, 1, 0, 0,0,0,0,0);
        chk(ctx_status[1:0] == 2'b01, "R6", "wake on runnable ignored", int'(ctx_status[1:0]), 1);
        step(0,0,0,0, 1, 1, 0,0,0,0,0);
        chk(ctx_status[3:2] == 2'b01, "R6", "ctx1 woken", int'(ctx_status[3:2]), 1);

        // R7 stop beats sleep; R3 restart reuses halted slot
        step(0,0, 1, 2, 0,0, 1, 2, 0,0,0);
        chk(ctx_status[5:4] == 2'b11, "R7", "stop wins over sleep", int'(ctx_status[5:4]), 3);
        idle(3);
        step(1, 16'h7000, 0,0,0,0,0,0,0,0,0);
        chk(ctx_status[5:4] == 2'b01, "R3", "halted slot reused", int'(ctx_status[5:4]), 1);
        idle(2);

        // R8: all parked gives bubbles
        for (int c = 0; c < N; c++) step(0,0, 1, c, 0,0,0,0,0,0,0);
        idle(1);
        chk(l_iv == 0, "R8", "all parked bubble", int'(l_iv), 0);
        chk(pipe_sleep == 1, "R8", "pipe_sleep all parked", int'(pipe_sleep), 1);
        for (int c = 0; c < N; c++) step(0,0,0,0, 1, c, 0,0,0,0,0);

        // random sweep against the model (R2..R10)
        for (int t = 0; t < 4000; t++) begin
            int r;
            r = int'($urandom);
            step((r % 10) < 3, int'($urandom) & 16'hffff,
                 ((r >> 4) % 10) == 0, (r >> 8) & 3,
                 ((r >> 10) % 10) < 4, (r >> 14) & 3,
                 ((r >> 16) % 20) == 0, (r >> 21) & 3,
                 ((r >> 23) % 4) == 0, (r >> 26) & 3, int'($urandom) & 16'hffff);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule